// File: doc/BRIEF.md
# Four-channel match timer with watchdog

This block is a memory-mapped operating-system timer. It has one 32-bit up-counter that advances on cycles where a tick enable is high. It also has four 32-bit compare channels. When the counter steps onto a channel's compare value, the channel records an event in its status bit and drives its interrupt line, but only if that channel's interrupt is enabled. Software acknowledges events by writing ones to the status register. Each acknowledged channel drops its own interrupt line; the others are untouched.

Channel 3 has a second use as a one-shot watchdog. If the watchdog arm bit is set when the counter reaches the channel 3 compare value, the block pulses a reset request for one cycle and clears the whole watchdog register. A program that does not want the reset must keep moving the channel 3 compare value ahead of the counter. The bus is a plain synchronous register port: address, write strobe, write data, and read data that is decoded combinationally from the current state.

Top module: `ostimer_match4`

## Requirements
- R1: After reset every register reads zero, all interrupt lines are low and the reset request is low.
- R2: The counter advances by one at each clock edge where tick_en is high, and it wraps from 0xFFFFFFFF to 0.
- R3: A write to the counter register (byte offset 0x10) loads the written value, and counting continues from it. A value loaded by a write never raises a compare event by itself, even if it equals a compare value.
- R4: When a tick moves the counter onto a channel's compare value and that channel's enable bit is 1, the status bit (bit i of the status register, offset 0x14) and irq[i] are high from that same clock edge.
- R5: A compare hit on a channel whose enable bit is 0 sets neither its status bit nor its interrupt.
- R6: A write to the status register clears each bit written as 1. Bits written as 0 keep their value. irq[i] falls with status bit i, and other channels are not affected.
- R7: The interrupt enable register (offset 0x1C, bit i enables channel i) stores only bits 11:0, and higher written bits read back as zero.
- R8: If bit 0 of the watchdog register (offset 0x18) is 1 when the counter reaches the channel 3 compare value, wdog_reset is high for exactly one cycle and the whole watchdog register becomes zero. This does not depend on the channel 3 interrupt enable.
- R9: If bit 0 of the watchdog register is 0, a channel 3 hit issues no reset request and the register keeps its value.
- R10: The compare registers at offsets 0x00, 0x04, 0x08 and 0x0C (channels 0 to 3) and the full 32-bit watchdog register read back exactly what was written.
- R11: Reads of any other offset, including offsets that are not word-aligned, return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Counter advance enable for this cycle |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 4 | Per-channel interrupt lines |
| wdog_reset | output | 1 | One-cycle reset request from the watchdog |

## Verification
The bench loads the counter with a value equal to a compare register to confirm that a load does not count as a hit. A design that compared the stored counter value instead of the stepping edge would raise a spurious interrupt there. It writes acknowledge masks that cover bits which are not set, and masks that leave set bits at zero, and checks that only the written-one channels drop. A design that cleared by assignment would lose pending events. It arms the watchdog with extra high bits while channel 3's interrupt is disabled. It expects one pulse and an all-zero register, which catches designs that gate the reset with the interrupt enable, hold the pulse, or clear only bit 0. It also drives the counter across the 32-bit wrap and writes the enable register with all ones to confirm the 12-bit truncation.

// File: rtl/ost_pkg.sv
package ost_pkg;
   localparam int unsigned SLOTS = 4;
   typedef enum logic [2:0] {
      IDX_CMP0 = 3'd0,
      IDX_CMP1 = 3'd1,
      IDX_CMP2 = 3'd2,
      IDX_CMP3 = 3'd3,
      IDX_CNT  = 3'd4,
      IDX_STAT = 3'd5,
      IDX_WDEN = 3'd6,
      IDX_IEN  = 3'd7
   } reg_idx_e;
endpackage

// File: rtl/ost_counter.sv
module ost_counter #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick_en,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] cnt,
   output logic [W-1:0] cnt_inc,
   output logic         step
);
   assign cnt_inc = cnt + W'(1);
   assign step    = tick_en && !load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (load) cnt <= load_val;
      else if (step) cnt <= cnt_inc;
   end
endmodule

// File: rtl/ost_channel.sv
module ost_channel #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_cmp,
   input  logic [W-1:0] wdata,
   input  logic         step,
   input  logic [W-1:0] cnt_inc,
   input  logic         en,
   input  logic         clr,
   output logic [W-1:0] cmp_val,
   output logic         hit,
   output logic         flag
);
   assign hit = step && (cnt_inc == cmp_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cmp_val <= '0;
      else if (wr_cmp) cmp_val <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         flag <= 1'b0;
      else if (hit && en) flag <= 1'b1;
      else if (clr)       flag <= 1'b0;
   end
endmodule

// File: rtl/ost_watchdog.sv
module ost_watchdog #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   input  logic         hit,
   output logic [W-1:0] arm,
   output logic         pulse
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arm   <= '0;
         pulse <= 1'b0;
      end else if (hit && arm[0]) begin
         arm   <= '0;
         pulse <= 1'b1;
      end else begin
         pulse <= 1'b0;
         if (wr) arm <= wdata;
      end
   end
endmodule

// File: rtl/ostimer_match4.sv
module ostimer_match4 import ost_pkg::*; #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned N_CH   = 4,
   parameter int unsigned IEN_W  = 12,
   parameter int unsigned WD_CH  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [N_CH-1:0]   irq,
   output logic              wdog_reset
);
   localparam int unsigned IDX_LO = 2;
   localparam int unsigned IDX_HI = IDX_LO + $bits(reg_idx_e) - 1;

   if (N_CH < 1 || N_CH > SLOTS) begin : g_bad_nch
      $error("N_CH must be 1 to 4");
   end
   if (WD_CH >= N_CH) begin : g_bad_wd
      $error("WD_CH must name an existing channel");
   end
   if (IEN_W < N_CH || IEN_W > DATA_W) begin : g_bad_ien
      $error("IEN_W must cover all channels and fit the bus");
   end
   if (ADDR_W <= IDX_HI + 1) begin : g_bad_addr
      $error("ADDR_W too small for the register window");
   end

   logic       reg_hit;
   reg_idx_e   idx;
   logic [7:0] wr_sel;

   assign reg_hit = (bus_addr[IDX_LO-1:0] == '0) && (bus_addr[ADDR_W-1:IDX_HI+1] == '0);
   assign idx     = reg_idx_e'(bus_addr[IDX_HI:IDX_LO]);

   always_comb begin
      wr_sel = '0;
      if (bus_we && reg_hit) wr_sel[idx] = 1'b1;
   end

   logic [DATA_W-1:0] cnt, cnt_inc;
   logic              step;

   ost_counter #(.W(DATA_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
      .load(wr_sel[IDX_CNT]), .load_val(bus_wdata),
      .cnt(cnt), .cnt_inc(cnt_inc), .step(step)
   );

   logic [IEN_W-1:0] ien;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 ien <= '0;
      else if (wr_sel[IDX_IEN])   ien <= bus_wdata[IEN_W-1:0];
   end

   logic [DATA_W-1:0] cmp_val [SLOTS];
   logic [SLOTS-1:0]  hit, flag;

   for (genvar i = 0; i < SLOTS; i++) begin : g_ch
      if (i < N_CH) begin : g_live
         ost_channel #(.W(DATA_W)) u_ch (
            .clk(clk), .rst_n(rst_n),
            .wr_cmp(wr_sel[i]), .wdata(bus_wdata),
            .step(step), .cnt_inc(cnt_inc),
            .en(ien[i]),
            .clr(wr_sel[IDX_STAT] && bus_wdata[i]),
            .cmp_val(cmp_val[i]), .hit(hit[i]), .flag(flag[i])
         );
      end else begin : g_none
         assign cmp_val[i] = '0;
         assign hit[i]     = 1'b0;
         assign flag[i]    = 1'b0;
      end
   end

   assign irq = flag[N_CH-1:0];

   logic [DATA_W-1:0] wd_arm;
   ost_watchdog #(.W(DATA_W)) u_wd (
      .clk(clk), .rst_n(rst_n),
      .wr(wr_sel[IDX_WDEN]), .wdata(bus_wdata),
      .hit(hit[WD_CH]),
      .arm(wd_arm), .pulse(wdog_reset)
   );

   always_comb begin
      bus_rdata = '0;
      if (reg_hit) begin
         unique case (idx)
            IDX_CMP0, IDX_CMP1,
            IDX_CMP2, IDX_CMP3: bus_rdata = cmp_val[idx[1:0]];
            IDX_CNT:            bus_rdata = cnt;
            IDX_STAT:           bus_rdata = DATA_W'(flag);
            IDX_WDEN:           bus_rdata = wd_arm;
            IDX_IEN:            bus_rdata = DATA_W'(ien);
            default:            bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/ost_checks.sv
module ost_checks #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned N_CH   = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_en,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_we,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [N_CH-1:0]   irq,
   input logic              wdog_reset,
   input logic [DATA_W-1:0] cnt
);
   logic cnt_wr, stat_wr, off_map;
   assign cnt_wr  = bus_we && (bus_addr == ADDR_W'(8'h10));
   assign stat_wr = bus_we && (bus_addr == ADDR_W'(8'h14));
   assign off_map = (bus_addr[1:0] != 2'b00) || (bus_addr > ADDR_W'(8'h1C));

   assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && !cnt_wr) |=> (cnt == $past(cnt) + DATA_W'(1)));

   assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_en && !cnt_wr) |=> $stable(cnt));

   assert_cnt_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> (cnt == $past(bus_wdata)));

   assert_irq_needs_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (|(irq & ~$past(irq))) |-> $past(tick_en && !cnt_wr));

   assert_ack_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && !tick_en) |=> ((irq & $past(bus_wdata[N_CH-1:0])) == '0));

   assert_wdog_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wdog_reset |=> !wdog_reset);

   assert_wdog_needs_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wdog_reset |-> $past(tick_en && !cnt_wr));

   assert_off_map_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      off_map |-> (bus_rdata == '0));
endmodule

bind ostimer_match4 ost_checks #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_CH(N_CH)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
   .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
   .irq(irq), .wdog_reset(wdog_reset), .cnt(cnt)
);

// File: tb/tb_ostimer_match4.sv
module tb_ostimer_match4;
   localparam int CLK_PERIOD = 10;
   localparam logic [7:0] A_CMP0 = 8'h00, A_CMP1 = 8'h04, A_CMP2 = 8'h08, A_CMP3 = 8'h0C;
   localparam logic [7:0] A_CNT = 8'h10, A_STAT = 8'h14, A_WDEN = 8'h18, A_IEN = 8'h1C;
   localparam int SEL_RD = 0, SEL_IRQ = 1, SEL_WD = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [3:0]  irq;
   logic        wdog_reset;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      int          sel;
      logic [31:0] exp;
      string       tag;
   } exp_t;
   exp_t sb[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   ostimer_match4 dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
      .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq(irq), .wdog_reset(wdog_reset)
   );

   task automatic cyc(input logic we, input logic [7:0] a, input logic [31:0] d, input logic tk);
      @(negedge clk);
      bus_we = we; bus_addr = a; bus_wdata = d; tick_en = tk;
   endtask

   task automatic expect_item(input int sel, input logic [31:0] e, input string tag);
      exp_t it;
      it.sel = sel; it.exp = e; it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      cyc(1'b1, a, d, 1'b0);
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
      cyc(1'b0, a, '0, 1'b0);
      expect_item(SEL_RD, e, tag);
   endtask

   task automatic tick(input int n);
      for (int k = 0; k < n; k++) cyc(1'b0, 8'h00, '0, 1'b1);
   endtask

   initial begin : monitor
      forever begin
         @(negedge clk);
         #2;
         while (sb.size() > 0) begin
            exp_t it;
            logic [31:0] act;
            it = sb.pop_front();
            case (it.sel)
               SEL_IRQ: act = {28'd0, irq};
               SEL_WD:  act = {31'd0, wdog_reset};
               default: act = bus_rdata;
            endcase
            checks++;
            if (act !== it.exp) begin
               errors++;
               $display("FAIL %s actual=0x%08h expected=0x%08h", it.tag, act, it.exp);
            end
         end
      end
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      rd(A_CMP0, 32'h0, "R1 cmp0");
      rd(A_CMP3, 32'h0, "R1 cmp3");
      rd(A_CNT,  32'h0, "R1 cnt");
      rd(A_STAT, 32'h0, "R1 stat");
      rd(A_WDEN, 32'h0, "R1 wden");
      rd(A_IEN,  32'h0, "R1 ien");
      expect_item(SEL_IRQ, 32'h0, "R1 irq");
      expect_item(SEL_WD,  32'h0, "R1 wdog");

      // R10: readback
      wr(A_CMP0, 32'h110); wr(A_CMP1, 32'h120);
      wr(A_CMP2, 32'h130); wr(A_CMP3, 32'h140);
      rd(A_CMP0, 32'h110, "R10 cmp0");
      rd(A_CMP1, 32'h120, "R10 cmp1");
      rd(A_CMP2, 32'h130, "R10 cmp2");
      rd(A_CMP3, 32'h140, "R10 cmp3");
      wr(A_WDEN, 32'hA5A5A5A4);
      rd(A_WDEN, 32'hA5A5A5A4, "R10 wden");

      // R7: enable truncation
      wr(A_IEN, 32'hFFFFFFFF);
      rd(A_IEN, 32'h00000FFF, "R7 ien");

      // R11: unmapped offsets
      wr(8'h24, 32'hDEADBEEF);
      wr(8'h11, 32'h12345678);
      rd(8'h24, 32'h0, "R11 rd 0x24");
      rd(8'h11, 32'h0, "R11 rd 0x11");
      rd(8'h80, 32'h0, "R11 rd 0x80");
      rd(A_CNT, 32'h0, "R11 cnt untouched");
      rd(A_IEN, 32'h00000FFF, "R11 ien untouched");

      // R3 / R2: load and count
      wr(A_CNT, 32'h100);
      rd(A_CNT, 32'h100, "R3 load");
      tick(5);
      rd(A_CNT, 32'h105, "R2 count");
      wr(A_CNT, 32'hFFFFFFFE);
      tick(3);
      rd(A_CNT, 32'h1, "R2 wrap");

      // R3: load equal to compare value is no event
      wr(A_CNT, 32'h110);
      rd(A_STAT, 32'h0, "R3 load no hit");
      expect_item(SEL_IRQ, 32'h0, "R3 irq after load");
      tick(1);
      rd(A_CNT, 32'h111, "R3 continue");
      rd(A_STAT, 32'h0, "R3 no late hit");

      // R4: enabled channel hit
      wr(A_IEN, 32'h5);
      wr(A_CNT, 32'h10C);
      tick(3);
      rd(A_CNT, 32'h10F, "R4 before hit cnt");
      expect_item(SEL_IRQ, 32'h0, "R4 before hit irq");
      tick(1);
      rd(A_STAT, 32'h1, "R4 stat");
      expect_item(SEL_IRQ, 32'h1, "R4 irq");

      // R5: disabled channel 1
      wr(A_CNT, 32'h11F);
      tick(1);
      rd(A_STAT, 32'h1, "R5 stat");
      expect_item(SEL_IRQ, 32'h1, "R5 irq");

      // R6: write one to clear
      wr(A_STAT, 32'h2);
      rd(A_STAT, 32'h1, "R6 zero keeps");
      wr(A_STAT, 32'hF);
      rd(A_STAT, 32'h0, "R6 clear");
      expect_item(SEL_IRQ, 32'h0, "R6 irq low");
      wr(A_CNT, 32'h12F); tick(1);
      wr(A_CNT, 32'h10F); tick(1);
      rd(A_STAT, 32'h5, "R6 two pending");
      expect_item(SEL_IRQ, 32'h5, "R6 two irq");
      wr(A_STAT, 32'h1);
      rd(A_STAT, 32'h4, "R6 per channel");
      expect_item(SEL_IRQ, 32'h4, "R6 per channel irq");
      wr(A_STAT, 32'h4);

      // R8: watchdog fire with channel 3 interrupt disabled
      wr(A_IEN, 32'h0);
      wr(A_WDEN, 32'hF0000003);
      wr(A_CNT, 32'h13F);
      tick(1);
      rd(A_WDEN, 32'h0, "R8 wden cleared");
      expect_item(SEL_WD,  32'h1, "R8 pulse");
      expect_item(SEL_IRQ, 32'h0, "R8 irq stays low");
      rd(A_STAT, 32'h0, "R8 stat");
      expect_item(SEL_WD,  32'h0, "R8 single cycle");

      // R9: disarmed watchdog
      wr(A_WDEN, 32'h2);
      wr(A_CNT, 32'h13F);
      tick(1);
      rd(A_WDEN, 32'h2, "R9 wden kept");
      expect_item(SEL_WD, 32'h0, "R9 no pulse");

      // R4: channel 3 as a plain interrupt
      wr(A_IEN, 32'h8);
      wr(A_CNT, 32'h13F);
      tick(1);
      rd(A_STAT, 32'h8, "R4 ch3 stat");
      expect_item(SEL_IRQ, 32'h8, "R4 ch3 irq");
      expect_item(SEL_WD,  32'h0, "R9 ch3 no pulse");

      cyc(1'b0, 8'h00, '0, 1'b0);
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule